// File: doc/BRIEF.md
# MAC Interrupt Status Aggregator

This block keeps the interrupt status and interrupt enable registers of an Ethernet MAC and drives two interrupt lines, one for transmit and one for receive. The transmit and receive engines report events through a 32-bit set vector. Each asserted bit sets the matching status bit, and that bit stays set until software clears it. Software clears status bits by writing ones to them. The upper half of the status word holds the transmit events and the lower half holds the receive events.

Each half has a summary bit inside the status word. A summary bit is high while at least one of its half's source events is both pending and enabled. The summary bit is then masked a second time by the enable bit at its own position before it drives the interrupt line. A separate global status register records when the transmit or receive path is switched from on to off. Software clears this register by writing ones. A soft-reset input clears all registers and drops both lines.

Top module: `mac_irq_agg`

## Requirements
- R1: An asserted bit of `evt_set` sets the status bit at the same position on the next clock edge, for every position except 10 and 24. The bit then stays set until software clears it.
- R2: A write to address 0 clears every status bit written as one. An event on the same bit in the same cycle wins, so that bit ends up set.
- R3: Status bit 24 is the transmit summary. It is 1 exactly when one of bits 18 (send complete), 23 (descriptor unavailable) or 29 (bus error) is set together with the enable bit at the same position. It is updated on the same edge as the event or the write.
- R4: Status bit 10 is the receive summary. It is computed the same way from bits 4 (good frame), 12 (descriptor unavailable) and 14 (bus error).
- R5: Bits 10 and 24 cannot be set by `evt_set` and cannot be cleared by a write. They always follow the R3 and R4 rule.
- R6: `irq_tx` equals status bit 24 AND enable bit 24, and `irq_rx` equals status bit 10 AND enable bit 10. Both change on the same edge as the status register.
- R7: A write to address 1 stores the full enable word. The word reads back unchanged at address 1, and both summaries and both lines are recomputed with the new enables on that edge.
- R8: Address 2 reads the global status word. Bit 1 is set when `tx_on` goes from 1 to 0, and bit 0 is set when `rx_on` goes from 1 to 0. Writing ones clears these bits, and a new halt in the same cycle wins. All other bits read 0.
- R9: While `srst` is high at a clock edge, the status, enable and global status registers become 0 and both lines go low on that edge. Events and halts in that cycle are dropped.
- R10: Reads of address 3 return 0, and writes to address 3 change no register.
- R11: After `rst_n` is low, all three registers read 0 and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| srst | input | 1 | Synchronous soft reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (2) | Word address: 0 status, 1 enable, 2 global status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_set | input | 32 | Event pulses from the engines, one bit per status position |
| tx_on | input | 1 | Transmit path enabled level |
| rx_on | input | 1 | Receive path enabled level |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_rx | output | 1 | Receive interrupt line |

## Verification
The bench targets the second mask. A source can be pending and enabled while the enable at the summary position is low. A design that skips the second mask would raise the line in that case. The bench also targets the summary bits themselves: it writes ones to them while their sources stay active, and it drives events at their positions. A design that treats them as ordinary W1C bits would drop them or set them wrongly. The bench also places an event and a clear on the same bit in the same cycle, and a halt and a clear on the same bit in the same cycle. A design with the wrong priority would lose the event or the halt. Finally, it checks that a soft reset wins over a simultaneous event; a wrong design would leave a stale status bit.

// File: rtl/mic_pkg.sv
package mic_pkg;

  localparam int DW   = 32;
  localparam int NGRP = 2;
  localparam int GRP_RX = 0;
  localparam int GRP_TX = 1;

  // receive half
  localparam int RX_GOOD_BIT = 4;
  localparam int RX_SUM_BIT  = 10;
  localparam int RX_NODESC_BIT = 12;
  localparam int RX_BUSERR_BIT = 14;
  // transmit half
  localparam int TX_DONE_BIT   = 18;
  localparam int TX_NODESC_BIT = 23;
  localparam int TX_SUM_BIT    = 24;
  localparam int TX_BUSERR_BIT = 29;

  localparam logic [DW-1:0] RX_SRC = (DW'(1) << RX_GOOD_BIT) |
                                     (DW'(1) << RX_NODESC_BIT) |
                                     (DW'(1) << RX_BUSERR_BIT);
  localparam logic [DW-1:0] TX_SRC = (DW'(1) << TX_DONE_BIT) |
                                     (DW'(1) << TX_NODESC_BIT) |
                                     (DW'(1) << TX_BUSERR_BIT);
  localparam logic [DW-1:0] SUM_MASK = (DW'(1) << RX_SUM_BIT) |
                                       (DW'(1) << TX_SUM_BIT);

  localparam int BIT_W = $clog2(DW);
  localparam logic [NGRP-1:0][DW-1:0]    GRP_SRC     = {TX_SRC, RX_SRC};
  localparam logic [NGRP-1:0][BIT_W-1:0] GRP_SUM_BIT = {BIT_W'(TX_SUM_BIT),
                                                        BIT_W'(RX_SUM_BIT)};

  // register word addresses
  localparam int ADDR_STAT = 0;
  localparam int ADDR_EN   = 1;
  localparam int ADDR_GLB  = 2;

  // global status positions (index equals group number)
  localparam int GLB_W = NGRP;

  // write-one-to-clear with set priority
  function automatic logic [DW-1:0] w1c_next(input logic [DW-1:0] q,
                                             input logic [DW-1:0] set,
                                             input logic [DW-1:0] clr);
    return (q & ~clr) | set;
  endfunction

  // any pending source that is also enabled
  function automatic logic group_hit(input logic [DW-1:0] stat,
                                     input logic [DW-1:0] en,
                                     input logic [DW-1:0] src);
    return |(stat & en & src);
  endfunction

endpackage

// File: rtl/mic_summary.sv
module mic_summary
  import mic_pkg::*;
#(
  parameter logic [DW-1:0] SRC_MASK = '0
) (
  input  logic [DW-1:0] stat,
  input  logic [DW-1:0] en,
  output logic          hit
);
  assign hit = group_hit(stat, en, SRC_MASK);
endmodule

// File: rtl/mic_evt_reg.sv
module mic_evt_reg
  import mic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            srst,
  input  logic [DW-1:0]   set_vec,
  input  logic [DW-1:0]   clr_vec,
  input  logic [DW-1:0]   en_nxt,
  input  logic [DW-1:0]   en_q,
  output logic [DW-1:0]   stat_q,
  output logic [NGRP-1:0] irq_q
);
  logic [DW-1:0]   raw_nxt;
  logic [DW-1:0]   sum_vec;
  logic [DW-1:0]   stat_nxt;
  logic [NGRP-1:0] sum_nxt;
  logic [NGRP-1:0] irq_nxt;

  // plain event bits, summary positions held out
  assign raw_nxt = w1c_next(stat_q & ~SUM_MASK, set_vec & ~SUM_MASK, clr_vec) & ~SUM_MASK;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    mic_summary #(.SRC_MASK(GRP_SRC[g])) u_sum (
      .stat (raw_nxt),
      .en   (en_nxt),
      .hit  (sum_nxt[g])
    );
    assign irq_nxt[g] = sum_nxt[g] & en_nxt[GRP_SUM_BIT[g]];
  end

  always_comb begin
    sum_vec = '0;
    for (int g = 0; g < NGRP; g++) sum_vec[GRP_SUM_BIT[g]] = sum_nxt[g];
  end

  assign stat_nxt = raw_nxt | sum_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      irq_q  <= '0;
    end else if (srst) begin
      stat_q <= '0;
      irq_q  <= '0;
    end else begin
      stat_q <= stat_nxt;
      irq_q  <= irq_nxt;
    end
  end

  // R3: transmit summary tracks enabled transmit sources
  a_r3_tx_summary: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[TX_SUM_BIT] == group_hit(stat_q, en_q, TX_SRC));
  // R4: receive summary tracks enabled receive sources
  a_r4_rx_summary: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[RX_SUM_BIT] == group_hit(stat_q, en_q, RX_SRC));
  // R1: an event outside summary positions lands in status
  a_r1_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst && |(set_vec & ~SUM_MASK)) |=>
      ((stat_q & $past(set_vec & ~SUM_MASK)) == $past(set_vec & ~SUM_MASK)));
  // R2: written ones clear unless an event hits the same bit
  a_r2_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> ((stat_q & $past(clr_vec & ~set_vec) & ~SUM_MASK) == '0));
  // R9: soft reset empties status and drops both lines
  a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (stat_q == '0 && irq_q == '0));

endmodule

// File: rtl/mic_halt_det.sv
module mic_halt_det
  import mic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic [NGRP-1:0]  run,
  input  logic [GLB_W-1:0] clr,
  output logic [GLB_W-1:0] halt_q
);
  logic [NGRP-1:0] run_prev;
  logic [NGRP-1:0] halt_evt;

  assign halt_evt = run_prev & ~run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_prev <= '0;
    else        run_prev <= run;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    halt_q[g] <= 1'b0;
      else if (srst) halt_q[g] <= 1'b0;
      else           halt_q[g] <= (halt_q[g] & ~clr[g]) | halt_evt[g];
    end

    // R8: an on-to-off transition is recorded
    a_r8_halt_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_evt[g] && !srst) |=> halt_q[g]);
    // R8: a cleared bit with no new halt drops
    a_r8_halt_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[g] && !halt_evt[g]) |=> !halt_q[g]);
  end

endmodule

// File: rtl/mac_irq_agg.sv
module mac_irq_agg
  import mic_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [DW-1:0]     evt_set,
  input  logic              tx_on,
  input  logic              rx_on,
  output logic              irq_tx,
  output logic              irq_rx
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(ADDR_EN);
  localparam logic [ADDR_W-1:0] A_GLB  = ADDR_W'(ADDR_GLB);

  logic             wr_stat, wr_en, wr_glb;
  logic [DW-1:0]    en_q, en_nxt;
  logic [DW-1:0]    stat_q;
  logic [DW-1:0]    stat_clr;
  logic [NGRP-1:0]  irq_q;
  logic [GLB_W-1:0] glb_q;
  logic [GLB_W-1:0] glb_clr;
  logic [NGRP-1:0]  run;

  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign wr_en   = reg_wr && (reg_addr == A_EN);
  assign wr_glb  = reg_wr && (reg_addr == A_GLB);

  assign en_nxt   = wr_en  ? reg_wdata : en_q;
  assign stat_clr = wr_stat ? reg_wdata : '0;
  assign glb_clr  = wr_glb ? reg_wdata[GLB_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_q <= '0;
    else if (srst) en_q <= '0;
    else           en_q <= en_nxt;
  end

  mic_evt_reg u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .srst    (srst),
    .set_vec (evt_set),
    .clr_vec (stat_clr),
    .en_nxt  (en_nxt),
    .en_q    (en_q),
    .stat_q  (stat_q),
    .irq_q   (irq_q)
  );

  always_comb begin
    run = '0;
    run[GRP_RX] = rx_on;
    run[GRP_TX] = tx_on;
  end

  mic_halt_det u_halt (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst   (srst),
    .run    (run),
    .clr    (glb_clr),
    .halt_q (glb_q)
  );

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = stat_q;
      A_EN:    reg_rdata = en_q;
      A_GLB:   reg_rdata = DW'(glb_q);
      default: reg_rdata = '0;
    endcase
  end

  assign irq_tx = irq_q[GRP_TX];
  assign irq_rx = irq_q[GRP_RX];

  // R6: each line is its summary masked by the enable at the summary position
  a_r6_tx_line: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx == (stat_q[TX_SUM_BIT] && en_q[TX_SUM_BIT]));
  a_r6_rx_line: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx == (stat_q[RX_SUM_BIT] && en_q[RX_SUM_BIT]));
  // R7: enable word only moves on its own write or soft reset
  a_r7_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !srst) |=> (en_q == $past(en_q)));

endmodule

// File: tb/sim_mac_irq_agg.sv
`timescale 1ns/1ps
module sim_mac_irq_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        srst = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] evt_set = '0;
  logic        tx_on = 1'b0;
  logic        rx_on = 1'b0;
  logic        irq_tx, irq_rx;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mac_irq_agg u0 (
    .clk(clk), .rst_n(rst_n), .srst(srst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
    .tx_on(tx_on), .rx_on(rx_on), .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  // {evt_set, wr, addr, wdata, expected status, expected irq_tx, expected irq_rx}
  localparam int NV = 14;
  localparam logic [100:0] VEC [NV] = '{
    {32'h00000010, 1'b0, 2'd0, 32'h00000000, 32'h00000010, 1'b0, 1'b0},
    {32'h00000000, 1'b1, 2'd1, 32'h00000410, 32'h00000410, 1'b0, 1'b1},
    {32'h00040000, 1'b0, 2'd0, 32'h00000000, 32'h00040410, 1'b0, 1'b1},
    {32'h00000000, 1'b1, 2'd1, 32'h01040410, 32'h01040410, 1'b1, 1'b1},
    {32'h00000000, 1'b1, 2'd0, 32'h00000010, 32'h01040000, 1'b1, 1'b0},
    {32'h00000000, 1'b1, 2'd1, 32'h00040410, 32'h01040000, 1'b0, 1'b0},
    {32'h00000010, 1'b1, 2'd0, 32'h00000010, 32'h01040410, 1'b0, 1'b1},
    {32'h00000000, 1'b1, 2'd0, 32'h01000400, 32'h01040410, 1'b0, 1'b1},
    {32'h01000400, 1'b1, 2'd0, 32'h00040010, 32'h00000000, 1'b0, 1'b0},
    {32'h00000400, 1'b0, 2'd0, 32'h00000000, 32'h00000000, 1'b0, 1'b0},
    {32'h00008001, 1'b0, 2'd0, 32'h00000000, 32'h00008001, 1'b0, 1'b0},
    {32'h20000000, 1'b0, 2'd0, 32'h00000000, 32'h20008001, 1'b0, 1'b0},
    {32'h00000000, 1'b1, 2'd1, 32'h21000000, 32'h21008001, 1'b1, 1'b0},
    {32'h00000000, 1'b1, 2'd0, 32'hFFFFFFFF, 32'h00000000, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // drive for one edge, then release inputs on the following negedge
  task automatic step(input logic [31:0] ev, input logic wr,
                      input logic [1:0] a, input logic [31:0] wd);
    @(negedge clk);
    evt_set = ev; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    @(negedge clk);
    evt_set = '0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11: reset state
    rd(2'd0, d); chk("R11", "status after reset", d, 32'h0);
    rd(2'd1, d); chk("R11", "enable after reset", d, 32'h0);
    rd(2'd2, d); chk("R11", "global after reset", d, 32'h0);
    chk("R11", "irq lines after reset", {30'b0, irq_tx, irq_rx}, 32'h0);

    // table: R1 R2 R3 R4 R5 R6 R7 across the rows
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][100:69], VEC[i][68], VEC[i][67:66], VEC[i][65:34]);
      rd(2'd0, d);
      chk("R1/R2/R3/R4/R5", $sformatf("status row %0d", i), d, VEC[i][33:2]);
      chk("R6", $sformatf("irq_tx row %0d", i), {31'b0, irq_tx}, {31'b0, VEC[i][1]});
      chk("R6", $sformatf("irq_rx row %0d", i), {31'b0, irq_rx}, {31'b0, VEC[i][0]});
    end

    // R7: enable word reads back
    rd(2'd1, d); chk("R7", "enable readback", d, 32'h21000000);

    // R8: halt capture on each path
    @(negedge clk); tx_on = 1'b1; rx_on = 1'b1;
    @(negedge clk); tx_on = 1'b0;
    @(negedge clk);
    rd(2'd2, d); chk("R8", "tx halt bit", d, 32'h2);
    rx_on = 1'b0;
    @(negedge clk);
    rd(2'd2, d); chk("R8", "rx halt bit", d, 32'h3);
    step(32'h0, 1'b1, 2'd2, 32'h2);
    rd(2'd2, d); chk("R8", "global w1c", d, 32'h1);
    // R8: halt in the same cycle as its clear wins
    tx_on = 1'b1;
    @(negedge clk);
    tx_on = 1'b0; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h2;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    rd(2'd2, d); chk("R8", "halt beats clear", d, 32'h3);

    // R10: unmapped address
    step(32'h0, 1'b1, 2'd3, 32'hFFFFFFFF);
    rd(2'd3, d); chk("R10", "unmapped read", d, 32'h0);
    rd(2'd1, d); chk("R10", "enable untouched", d, 32'h21000000);
    rd(2'd0, d); chk("R10", "status untouched", d, 32'h0);
    rd(2'd2, d); chk("R10", "global untouched", d, 32'h3);

    // R9: soft reset beats a same-cycle event
    step(32'h20000000, 1'b0, 2'd0, 32'h0);
    rd(2'd0, d); chk("R3", "tx source pending", d, 32'h21000000);
    chk("R6", "irq_tx before soft reset", {31'b0, irq_tx}, 32'h1);
    @(negedge clk); srst = 1'b1; evt_set = 32'h00000010;
    @(negedge clk); srst = 1'b0; evt_set = '0;
    rd(2'd0, d); chk("R9", "status after soft reset", d, 32'h0);
    rd(2'd1, d); chk("R9", "enable after soft reset", d, 32'h0);
    rd(2'd2, d); chk("R9", "global after soft reset", d, 32'h0);
    chk("R9", "irq lines after soft reset", {30'b0, irq_tx, irq_rx}, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule